// File: doc/BRIEF.md
# Correlated-Word Attribute Resolver

This controller settles a single attribute bit that is carried implicitly by the check bits of every codeword in a cache line, rather than being stored in the array. A line holds `NUM_WORDS` codewords, 64-bit data words in the default line of 512 bits. The same attribute value is folded into the check bits of each codeword when the line is written. On a read, the upstream syndrome logic decodes the requested word twice, once assuming attribute 0 and once assuming attribute 1. It passes both syndromes to this block.

If exactly one of the two hypotheses decodes without error, the attribute follows from that hypothesis and the controller finishes at once. If both show errors, the requested word alone can produce a miscorrection. The controller then reads the other words of the line one after another through a request/response port and receives each word's pair of syndromes. Because all words share the attribute, these siblings decide its value. With that value fixed, the controller either confirms the requested word's single-error correction or declares the word uncorrectable.

A syndrome is classed as follows: all zeros means no error, odd weight means a single (correctable) error, and nonzero even weight means a multiple error. Hypothesis 0 always corresponds to attribute value 0.

Top module: `attr_resolve_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `rd_valid` are low, `attr` is 0 and `status` is 2'b00.
- R2: When exactly one of the requested word's hypotheses is error-free, `attr` takes that hypothesis's value, `status` is 2'b00 (clean), no read is issued, and `done` rises two cycles after the request is accepted.
- R3: When both of the requested word's hypotheses are error-free, the attribute cannot be inferred: `status` is 2'b11 (undetermined), `attr` is 0, and no read is issued.
- R4: When both hypotheses of the requested word show errors, the other words are read in ascending index order and the requested index is skipped. A new read is only issued after the response to the previous one, and a new read appears one cycle after that response.
- R5: The first sibling word with exactly one error-free hypothesis fixes the attribute to that hypothesis's value, and no further reads are issued for the request.
- R6: Once the line attribute A has been resolved, `status` is 2'b01 (corrected) if the requested word's hypothesis A shows a single error. It is 2'b10 (uncorrectable) if that hypothesis shows a multiple error, even when the other hypothesis has fewer errors.
- R7: If no sibling has exactly one error-free hypothesis, every single-error hypothesis over all siblings is one vote for its value, and the larger count wins, with R6 then applied. Equal nonzero counts give `status` 2'b10 and `attr` 0.
- R8: If no sibling gives either a clean hypothesis or a vote, `status` is 2'b11 and `attr` is 0.
- R9: `done` is high for exactly one cycle per accepted request. `attr` and `status` change only on entry to that cycle and then hold until the next result.
- R10: `busy` is high from the cycle after a request is accepted through the `done` cycle. A `req_valid` seen while `busy` is high is ignored and alters neither the reads nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_idx | input | IDX_W | Position of the requested word in the line |
| req_syn_a0 | input | SYN_W | Requested word syndrome assuming attribute 0 |
| req_syn_a1 | input | SYN_W | Requested word syndrome assuming attribute 1 |
| busy | output | 1 | A request is in progress |
| rd_valid | output | 1 | One-cycle read request for a sibling word |
| rd_idx | output | IDX_W | Index of the sibling word being read |
| rsp_valid | input | 1 | One-cycle response carrying the sibling's syndromes |
| rsp_syn_a0 | input | SYN_W | Sibling syndrome assuming attribute 0 |
| rsp_syn_a1 | input | SYN_W | Sibling syndrome assuming attribute 1 |
| done | output | 1 | One-cycle completion pulse |
| attr | output | 1 | Resolved attribute value |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 undetermined |

## Verification
The hardest outcome to reach is the overruled miscorrection. In that case the requested word alone would choose one attribute by fewest errors, while a later sibling decodes cleanly with the other value. The bench builds such lines directly: it gives the requested word a single-error hypothesis against a multiple-error one, and it places the first clean sibling behind one or more siblings that have no clean hypothesis. This forces both the skip-and-scan order and the reversal. Vote ties and lines with no evidence at all are built in the same way, with the requested word set at the first, middle and last index so that the skip is exercised at every edge. An extra request is injected while a scan is in flight, to show that it is ignored.

// File: rtl/attr_res_pkg.sv
package attr_res_pkg;

    typedef enum logic [1:0] {
        SYN_NONE   = 2'b00,
        SYN_SINGLE = 2'b01,
        SYN_MULTI  = 2'b10
    } syn_class_e;

    typedef enum logic [1:0] {
        RES_CLEAN  = 2'b00,
        RES_CORR   = 2'b01,
        RES_UNCORR = 2'b10,
        RES_UNDET  = 2'b11
    } res_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_WAIT,
        S_EVAL,
        S_DONE
    } ctrl_state_e;

    // Outcome for the requested word once the line attribute is known.
    function automatic res_status_e judge_word(syn_class_e hyp_cls);
        return (hyp_cls == SYN_SINGLE) ? RES_CORR : RES_UNCORR;
    endfunction

endpackage

// File: rtl/attr_syn_classify.sv
module attr_syn_classify
    import attr_res_pkg::*;
#(
    parameter int SYN_W = 8
) (
    input  logic [SYN_W-1:0] syn,
    output syn_class_e       cls
);
    always_comb begin
        if (syn == '0) begin
            cls = SYN_NONE;
        end else if (^syn) begin
            cls = SYN_SINGLE;
        end else begin
            cls = SYN_MULTI;
        end
    end
endmodule

// File: rtl/attr_vote_tally.sv
module attr_vote_tally #(
    parameter int MAX_VOTES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic add_a0,
    input  logic add_a1,
    output logic any_vote,
    output logic tie,
    output logic winner
);
    localparam int CW = $clog2(MAX_VOTES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt0;
        logic [CW-1:0] cnt1;
    } tally_t;

    tally_t tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (clear) begin
            tally_d.cnt0 = '0;
            tally_d.cnt1 = '0;
        end else begin
            if (add_a0) tally_d.cnt0 = tally_q.cnt0 + CW'(1);
            if (add_a1) tally_d.cnt1 = tally_q.cnt1 + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign any_vote = (tally_q.cnt0 != '0) || (tally_q.cnt1 != '0);
    assign tie      = any_vote && (tally_q.cnt0 == tally_q.cnt1);
    assign winner   = (tally_q.cnt1 > tally_q.cnt0);
endmodule

// File: rtl/attr_resolve_ctrl.sv
module attr_resolve_ctrl
    import attr_res_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int SYN_W     = 8,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [SYN_W-1:0] req_syn_a0,
    input  logic [SYN_W-1:0] req_syn_a1,
    output logic             busy,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             rsp_valid,
    input  logic [SYN_W-1:0] rsp_syn_a0,
    input  logic [SYN_W-1:0] rsp_syn_a1,
    output logic             done,
    output logic             attr,
    output logic [1:0]       status
);
    localparam int PTR_W   = IDX_W + 1;
    localparam int N_CLASS = 4;

    typedef struct packed {
        ctrl_state_e   st;
        logic [IDX_W-1:0] home;
        syn_class_e    h0;
        syn_class_e    h1;
        logic [PTR_W-1:0] ptr;
        logic          found;
        logic          found_attr;
        logic          attr;
        res_status_e   status;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;

    // Classifiers: 0/1 requested word, 2/3 sibling response.
    logic [N_CLASS-1:0][SYN_W-1:0] syn_bus;
    syn_class_e                    cls_w [N_CLASS];

    assign syn_bus = {rsp_syn_a1, rsp_syn_a0, req_syn_a1, req_syn_a0};

    for (genvar g = 0; g < N_CLASS; g++) begin : g_cls
        attr_syn_classify #(.SYN_W(SYN_W)) u_cls (
            .syn (syn_bus[g]),
            .cls (cls_w[g])
        );
    end

    // Sibling evidence from the current response.
    logic sib_clean_one;
    logic sib_clean_attr;
    assign sib_clean_one  = (cls_w[2] == SYN_NONE) ^ (cls_w[3] == SYN_NONE);
    assign sib_clean_attr = (cls_w[3] == SYN_NONE);

    logic tally_clear, vote_a0, vote_a1;
    logic any_vote, vote_tie, vote_winner;

    attr_vote_tally #(.MAX_VOTES(NUM_WORDS)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tally_clear),
        .add_a0   (vote_a0),
        .add_a1   (vote_a1),
        .any_vote (any_vote),
        .tie      (vote_tie),
        .winner   (vote_winner)
    );

    function automatic logic [PTR_W-1:0] step_ptr(logic [PTR_W-1:0] cur,
                                                  logic [IDX_W-1:0] skip);
        logic [PTR_W-1:0] nxt;
        nxt = cur + PTR_W'(1);
        if (nxt == {1'b0, skip}) nxt = nxt + PTR_W'(1);
        return nxt;
    endfunction

    logic             accept;
    logic             rsp_take;
    logic [PTR_W-1:0] ptr_next;
    syn_class_e       home_cls_sel;

    assign accept   = (ctrl_q.st == S_IDLE) && req_valid;
    assign rsp_take = (ctrl_q.st == S_WAIT) && rsp_valid;
    assign ptr_next = step_ptr(ctrl_q.ptr, ctrl_q.home);

    assign tally_clear = accept;
    assign vote_a0     = rsp_take && !sib_clean_one && (cls_w[2] == SYN_SINGLE);
    assign vote_a1     = rsp_take && !sib_clean_one && (cls_w[3] == SYN_SINGLE);

    always_comb begin
        ctrl_d       = ctrl_q;
        home_cls_sel = SYN_MULTI;

        unique case (ctrl_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    ctrl_d.st    = S_CHECK;
                    ctrl_d.home  = req_idx;
                    ctrl_d.h0    = cls_w[0];
                    ctrl_d.h1    = cls_w[1];
                    ctrl_d.ptr   = (req_idx == '0) ? PTR_W'(1) : '0;
                    ctrl_d.found = 1'b0;
                end
            end

            S_CHECK: begin
                if (ctrl_q.h0 == SYN_NONE && ctrl_q.h1 == SYN_NONE) begin
                    ctrl_d.attr   = 1'b0;
                    ctrl_d.status = RES_UNDET;
                    ctrl_d.st     = S_DONE;
                end else if (ctrl_q.h0 == SYN_NONE) begin
                    ctrl_d.attr   = 1'b0;
                    ctrl_d.status = RES_CLEAN;
                    ctrl_d.st     = S_DONE;
                end else if (ctrl_q.h1 == SYN_NONE) begin
                    ctrl_d.attr   = 1'b1;
                    ctrl_d.status = RES_CLEAN;
                    ctrl_d.st     = S_DONE;
                end else if (ctrl_q.ptr >= PTR_W'(NUM_WORDS)) begin
                    ctrl_d.st = S_EVAL;
                end else begin
                    ctrl_d.st = S_FETCH;
                end
            end

            S_FETCH: begin
                ctrl_d.st = S_WAIT;
            end

            S_WAIT: begin
                if (rsp_valid) begin
                    if (sib_clean_one) begin
                        ctrl_d.found      = 1'b1;
                        ctrl_d.found_attr = sib_clean_attr;
                        ctrl_d.st         = S_EVAL;
                    end else if (ptr_next >= PTR_W'(NUM_WORDS)) begin
                        ctrl_d.st = S_EVAL;
                    end else begin
                        ctrl_d.ptr = ptr_next;
                        ctrl_d.st  = S_FETCH;
                    end
                end
            end

            S_EVAL: begin
                ctrl_d.st = S_DONE;
                if (ctrl_q.found) begin
                    home_cls_sel  = ctrl_q.found_attr ? ctrl_q.h1 : ctrl_q.h0;
                    ctrl_d.attr   = ctrl_q.found_attr;
                    ctrl_d.status = judge_word(home_cls_sel);
                end else if (vote_tie) begin
                    ctrl_d.attr   = 1'b0;
                    ctrl_d.status = RES_UNCORR;
                end else if (any_vote) begin
                    home_cls_sel  = vote_winner ? ctrl_q.h1 : ctrl_q.h0;
                    ctrl_d.attr   = vote_winner;
                    ctrl_d.status = judge_word(home_cls_sel);
                end else begin
                    ctrl_d.attr   = 1'b0;
                    ctrl_d.status = RES_UNDET;
                end
            end

            S_DONE: begin
                ctrl_d.st = S_IDLE;
            end

            default: begin
                ctrl_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q            <= '0;
            ctrl_q.st         <= S_IDLE;
            ctrl_q.h0         <= SYN_NONE;
            ctrl_q.h1         <= SYN_NONE;
            ctrl_q.status     <= RES_CLEAN;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy     = (ctrl_q.st != S_IDLE);
    assign rd_valid = (ctrl_q.st == S_FETCH);
    assign rd_idx   = ctrl_q.ptr[IDX_W-1:0];
    assign done     = (ctrl_q.st == S_DONE);
    assign attr     = ctrl_q.attr;
    assign status   = ctrl_q.status;
endmodule

// File: rtl/attr_resolve_chk.sv
module attr_resolve_chk #(
    parameter int NUM_WORDS = 8,
    parameter int SYN_W     = 8,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic [SYN_W-1:0] req_syn_a0,
    input logic [SYN_W-1:0] req_syn_a1,
    input logic             busy,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rsp_valid,
    input logic [SYN_W-1:0] rsp_syn_a0,
    input logic [SYN_W-1:0] rsp_syn_a1,
    input logic             done,
    input logic             attr,
    input logic [1:0]       status
);
    logic [IDX_W-1:0] home_q;
    logic [IDX_W-1:0] last_q;
    logic             seen_q;
    logic             pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            home_q    <= '0;
            last_q    <= '0;
            seen_q    <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                home_q <= req_idx;
                seen_q <= 1'b0;
            end
            if (rd_valid) begin
                last_q    <= rd_idx;
                seen_q    <= 1'b1;
                pending_q <= 1'b1;
            end else if (rsp_valid) begin
                pending_q <= 1'b0;
            end
        end
    end

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(status) && $stable(attr))); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R10

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10

    AST_SKIP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_idx != home_q)); // R4

    AST_ASCENDING_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && seen_q) |-> (rd_idx > last_q)); // R4

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && seen_q) |-> !pending_q); // R4

    AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (int'(rd_idx) < NUM_WORDS)); // R4
endmodule

bind attr_resolve_ctrl attr_resolve_chk #(
    .NUM_WORDS (NUM_WORDS),
    .SYN_W     (SYN_W),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/attr_resolve_ctrl_bench.sv
module attr_resolve_ctrl_bench;
    localparam int NW    = 8;
    localparam int SW    = 8;
    localparam int IW    = $clog2(NW);
    localparam logic [SW-1:0] SY_CLEAN  = 8'h00;
    localparam logic [SW-1:0] SY_SINGLE = 8'h01;
    localparam logic [SW-1:0] SY_SINGLE3 = 8'h0b;
    localparam logic [SW-1:0] SY_MULTI  = 8'h03;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_idx = '0;
    logic [SW-1:0] req_syn_a0 = '0;
    logic [SW-1:0] req_syn_a1 = '0;
    logic          busy;
    logic          rd_valid;
    logic [IW-1:0] rd_idx;
    logic          rsp_valid = 1'b0;
    logic [SW-1:0] rsp_syn_a0 = '0;
    logic [SW-1:0] rsp_syn_a1 = '0;
    logic          done;
    logic          attr;
    logic [1:0]    status;

    always #2.5 clk = ~clk;

    attr_resolve_ctrl #(.NUM_WORDS(NW), .SYN_W(SW)) u_attr_resolve_ctrl (.*);

    int n_checks = 0;
    int n_fails  = 0;

    logic [SW-1:0] line_a0 [NW];
    logic [SW-1:0] line_a1 [NW];

    int exp_reads[$];
    int exp_attr;
    int exp_status;

    task automatic check(string req, string what, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    function automatic int cls_of(logic [SW-1:0] s);
        if (s == '0) return 0;
        if (($countones(s) % 2) == 1) return 1;
        return 2;
    endfunction

    // Behavioural reference: expected reads, attribute and status.
    task automatic model(int home);
        int c0 = cls_of(line_a0[home]);
        int c1 = cls_of(line_a1[home]);
        int v0 = 0;
        int v1 = 0;
        int a = -1;
        exp_reads.delete();
        if (c0 == 0 && c1 == 0) begin exp_attr = 0; exp_status = 3; return; end
        if (c0 == 0) begin exp_attr = 0; exp_status = 0; return; end
        if (c1 == 0) begin exp_attr = 1; exp_status = 0; return; end
        for (int i = 0; i < NW; i++) begin
            int s0, s1;
            if (i == home) continue;
            exp_reads.push_back(i);
            s0 = cls_of(line_a0[i]);
            s1 = cls_of(line_a1[i]);
            if ((s0 == 0) != (s1 == 0)) begin a = (s1 == 0) ? 1 : 0; break; end
            if (s0 == 1) v0++;
            if (s1 == 1) v1++;
        end
        if (a < 0) begin
            if (v0 + v1 == 0) begin exp_attr = 0; exp_status = 3; return; end
            if (v0 == v1) begin exp_attr = 0; exp_status = 2; return; end
            a = (v1 > v0) ? 1 : 0;
        end
        exp_attr = a;
        exp_status = (((a == 1) ? c1 : c0) == 1) ? 1 : 2;
    endtask

    task automatic fill_line(logic [SW-1:0] a0, logic [SW-1:0] a1);
        for (int i = 0; i < NW; i++) begin
            line_a0[i] = a0;
            line_a1[i] = a1;
        end
    endtask

    // Issues one request and follows it cycle by cycle against the model.
    task automatic run_case(string req, int home, int lat, bit intrude);
        int  cyc = 0;
        int  rsp_due = -1;
        int  n_reads;
        int  exp_done_cyc;
        int  got_done = 0;
        int  last_rd = -1;
        model(home);
        n_reads = exp_reads.size();
        exp_done_cyc = (n_reads == 0) ? 2 : 2 + n_reads * (lat + 1) + 1;
        @(negedge clk);
        req_valid  = 1'b1;
        req_idx    = IW'(home);
        req_syn_a0 = line_a0[home];
        req_syn_a1 = line_a1[home];
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (got_done == 0 && cyc < 200) begin
            cyc++;
            if (cyc > 1) @(negedge clk);
            rsp_valid = 1'b0;
            check("R10", "busy while in flight", int'(busy), 1);
            if (rd_valid) begin
                if (exp_reads.size() == 0) begin
                    check("R5", "unexpected read", int'(rd_idx), -1);
                end else begin
                    check("R4", "read index", int'(rd_idx), exp_reads.pop_front());
                    if (last_rd >= 0) check("R4", "read spacing", cyc - last_rd, lat + 1);
                end
                last_rd = cyc;
                rsp_due = cyc + lat;
            end
            if (cyc == rsp_due) begin
                rsp_valid  = 1'b1;
                rsp_syn_a0 = line_a0[rd_idx];
                rsp_syn_a1 = line_a1[rd_idx];
                if (intrude) begin
                    req_valid  = 1'b1;
                    req_idx    = IW'((home + 1) % NW);
                    req_syn_a0 = SY_CLEAN;
                    req_syn_a1 = SY_SINGLE;
                end
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                got_done = 1;
                check(req, "attr", int'(attr), exp_attr);
                check(req, "status", int'(status), exp_status);
                check("R9", "done cycle", cyc, exp_done_cyc);
                check("R5", "reads left", exp_reads.size(), 0);
            end
        end
        rsp_valid = 1'b0;
        req_valid = 1'b0;
        check("R9", "done seen", got_done, 1);
        @(negedge clk);
        check("R9", "done drops", int'(done), 0);
        check("R10", "idle after done", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R9", "status held", int'(status), exp_status);
        check("R9", "attr held", int'(attr), exp_attr);
        check("R9", "no stray done", int'(done), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "rd_valid", int'(rd_valid), 0);
        check("R1", "status", int'(status), 0);
        check("R1", "attr", int'(attr), 0);
        rst_n = 1'b1;

        // R2: attribute 0 decodes cleanly
        fill_line(SY_CLEAN, SY_MULTI);
        line_a1[3] = SY_SINGLE;
        run_case("R2", 3, 1, 1'b0);
        // R2: attribute 1 decodes cleanly
        fill_line(SY_MULTI, SY_CLEAN);
        run_case("R2", 0, 1, 1'b0);
        // R3: both hypotheses clean
        fill_line(SY_CLEAN, SY_CLEAN);
        run_case("R3", 5, 1, 1'b0);

        // R6: requested word leans to 0, sibling 1 says 1 -> uncorrectable
        fill_line(SY_MULTI, SY_MULTI);
        line_a0[2] = SY_SINGLE;  line_a1[2] = SY_MULTI;
        line_a0[0] = SY_MULTI;   line_a1[0] = SY_SINGLE;
        line_a0[1] = SY_MULTI;   line_a1[1] = SY_CLEAN;
        line_a0[3] = SY_CLEAN;   line_a1[3] = SY_MULTI;
        run_case("R6", 2, 1, 1'b0);
        // R10: same line, intruding request while scanning
        run_case("R10", 2, 2, 1'b1);

        // R5: home 0, sibling 2 confirms attribute 0 -> corrected
        fill_line(SY_MULTI, SY_MULTI);
        line_a0[0] = SY_SINGLE3; line_a1[0] = SY_MULTI;
        line_a0[2] = SY_CLEAN;   line_a1[2] = SY_SINGLE;
        run_case("R5", 0, 3, 1'b0);

        // R7: majority for 1, home last
        fill_line(SY_MULTI, SY_SINGLE);
        line_a0[7] = SY_SINGLE; line_a1[7] = SY_SINGLE3;
        line_a0[1] = SY_SINGLE;
        run_case("R7", 7, 1, 1'b0);
        // R7: majority for 0 while home hypothesis 0 is multiple
        fill_line(SY_SINGLE, SY_MULTI);
        line_a0[6] = SY_MULTI; line_a1[6] = SY_SINGLE;
        run_case("R7", 6, 2, 1'b0);
        // R7: tie
        fill_line(SY_MULTI, SY_MULTI);
        line_a0[4] = SY_SINGLE; line_a1[4] = SY_SINGLE;
        line_a0[0] = SY_SINGLE; line_a1[1] = SY_SINGLE;
        line_a0[5] = SY_SINGLE; line_a1[5] = SY_SINGLE;
        run_case("R7", 4, 1, 1'b0);

        // R8: no evidence anywhere
        fill_line(SY_MULTI, SY_MULTI);
        run_case("R8", 3, 1, 1'b0);
        // R8: siblings both clean give no evidence either
        fill_line(SY_CLEAN, SY_CLEAN);
        line_a0[1] = SY_MULTI; line_a1[1] = SY_SINGLE;
        run_case("R8", 1, 1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule